// File: doc/BRIEF.md
# Palette Color Lookup with Overlay Selection

This block turns a stream of pixels, one per clock, into 24-bit color words for a triple video converter. Each pixel has an 8-bit color index, a 2-bit overlay code, and active-low sync and blank strobes. The color comes either from a 256-entry palette memory or from one of four overlay color registers. A control bit in a command register decides whether overlay code zero looks up the palette or shows overlay color zero.

A byte-wide microprocessor port loads and reads back the palette, the overlay colors and the command register. Palette and overlay entries are moved as three bytes (red, green, blue) through a data register. The entry address steps forward by itself after each blue byte, so a whole table loads as one burst. Color outputs, the blank flag and the green-only sync flag all leave the block two clocks after the pixel that produced them.

Top module: `pal_lut_top`

## Requirements
- R1: With overlay code 1, 2 or 3 on `pix_ovl_i`, the color is overlay register 1, 2 or 3. The pixel index and the command register do not affect it.
- R2: With overlay code 0 and command register bit 6 set, the color is the palette entry addressed by `pix_idx_i`.
- R3: With overlay code 0 and command register bit 6 clear, the color is overlay register 0, whatever the pixel index.
- R4: When `pix_blank_ni` is low, red, green and blue come out as zero two clocks later. `blank_no` repeats `pix_blank_ni` with the same two-clock delay.
- R5: `grn_sync_no` repeats `pix_sync_ni` with a two-clock delay. No red or blue output depends on sync.
- R6: A new pixel is accepted every clock, and its color appears exactly two rising edges after it is presented.
- R7: A write to register 0 sets the palette address and restarts the byte order at red. Writes to register 1 take red, then green, then blue. The blue byte stores the 24-bit entry and advances the address, which wraps from 255 to 0. A read of register 0 returns the address.
- R8: Reads of register 1 return the addressed entry's red, green and blue bytes in turn and advance the address after blue. `cpu_rdata_o` is updated at the edge that takes the read and holds its value until the next read.
- R9: Register 3 sets a 2-bit overlay address and restarts the byte order. Register 4 writes and reads overlay colors with the same red/green/blue order, advancing and wrapping the overlay address after blue. A read of register 3 returns the overlay address.
- R10: Register 2 is the command register. It can be written and read at any time, and data bit n maps to command bit n.
- R11: If a palette blue-byte write and a pixel lookup hit the same entry in the same cycle, the pixel gets the old contents. Later lookups get the new contents.
- R12: While `rst_ni` is low: color outputs are zero, `blank_no` is low, `grn_sync_no` is high, `cpu_rdata_o` is zero, and both byte orders restart at red with address zero. The command register, palette and overlay colors are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel and port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_idx_i | input | 8 | Pixel color index |
| pix_ovl_i | input | 2 | Pixel overlay code |
| pix_sync_ni | input | 1 | Pixel sync strobe, active low |
| pix_blank_ni | input | 1 | Pixel blank strobe, active low |
| cpu_we_i | input | 1 | Port write strobe (takes priority over read) |
| cpu_re_i | input | 1 | Port read strobe |
| cpu_reg_i | input | 3 | Register select: 0 palette address, 1 palette data, 2 command, 3 overlay address, 4 overlay data |
| cpu_wdata_i | input | 8 | Port write data |
| cpu_rdata_o | output | 8 | Port read data, registered |
| red_o | output | 8 | Red code |
| grn_o | output | 8 | Green code |
| blu_o | output | 8 | Blue code |
| blank_no | output | 1 | Delayed blank flag, active low |
| grn_sync_no | output | 1 | Delayed sync flag for the green converter, active low |

## Verification
The hardest case to reach is a port write landing on the palette entry that a pixel is looking up in the same cycle. It only happens on the third byte of a transfer, and only while overlay code 0 and the palette bit route that entry to the output. The bench sets this up on purpose: it loads the address, writes two bytes, then presents the blue byte together with a pixel carrying that index. It then holds the index to see the new value arrive one pixel later. A long randomized phase mixes command changes, partial transfers and readbacks with random pixels, so byte-order restarts and address wraps occur while pixels are flowing.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [2:0] {
    REG_PAL_ADDR = 3'd0,
    REG_PAL_DATA = 3'd1,
    REG_CMD      = 3'd2,
    REG_OVL_ADDR = 3'd3,
    REG_OVL_DATA = 3'd4
  } cpu_reg_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } byte_ph_e;

  function automatic byte_ph_e ph_next(byte_ph_e ph);
    case (ph)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  pix_addr_i,
  output logic [WORD_W-1:0] pix_word_o,
  input  logic [IDX_W-1:0]  cpu_addr_i,
  output logic [WORD_W-1:0] cpu_word_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] pix_word_q;

  // read-before-write: a same-cycle pixel read sees the old entry
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    pix_word_q <= mem_q[pix_addr_i];
  end

  assign pix_word_o = pix_word_q;
  assign cpu_word_o = mem_q[cpu_addr_i];
endmodule

// File: rtl/pal_cpu_port.sv
module pal_cpu_port
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int OVL_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        re_i,
  input  logic [2:0]                  reg_i,
  input  logic [CH_W-1:0]             wdata_i,
  output logic [CH_W-1:0]             rdata_o,
  output logic                        pal_we_o,
  output logic [IDX_W-1:0]            pal_addr_o,
  output logic [3*CH_W-1:0]           pal_wdata_o,
  input  logic [3*CH_W-1:0]           pal_rword_i,
  output logic [CH_W-1:0]             cmd_o,
  output logic [(1<<OVL_W)*3*CH_W-1:0] ovl_regs_o
);
  localparam int WORD_W = 3 * CH_W;
  localparam int N_OVL  = 1 << OVL_W;

  logic [IDX_W-1:0]  pal_addr_q;
  logic [OVL_W-1:0]  ovl_addr_q;
  byte_ph_e          pal_ph_q, ovl_ph_q;
  logic [2*CH_W-1:0] pal_hold_q, ovl_hold_q;
  logic [CH_W-1:0]   rdata_q;
  logic [CH_W-1:0]   cmd_q;
  logic [WORD_W-1:0] ovl_q [N_OVL];

  logic wr_pal_addr, wr_pal_data, wr_cmd, wr_ovl_addr, wr_ovl_data;
  logic rd_pal_data, rd_ovl_data, ovl_we;

  always_comb begin
    wr_pal_addr = we_i && (reg_i == REG_PAL_ADDR);
    wr_pal_data = we_i && (reg_i == REG_PAL_DATA);
    wr_cmd      = we_i && (reg_i == REG_CMD);
    wr_ovl_addr = we_i && (reg_i == REG_OVL_ADDR);
    wr_ovl_data = we_i && (reg_i == REG_OVL_DATA);
    rd_pal_data = !we_i && re_i && (reg_i == REG_PAL_DATA);
    rd_ovl_data = !we_i && re_i && (reg_i == REG_OVL_DATA);
    ovl_we      = wr_ovl_data && (ovl_ph_q == PH_BLU);
  end

  function automatic logic [CH_W-1:0] pick(logic [WORD_W-1:0] w, byte_ph_e ph);
    case (ph)
      PH_RED:  return w[3*CH_W-1:2*CH_W];
      PH_GRN:  return w[2*CH_W-1:CH_W];
      default: return w[CH_W-1:0];
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pal_addr_q <= '0;
      ovl_addr_q <= '0;
      pal_ph_q   <= PH_RED;
      ovl_ph_q   <= PH_RED;
      pal_hold_q <= '0;
      ovl_hold_q <= '0;
      rdata_q    <= '0;
    end else begin
      if (wr_pal_addr) begin
        pal_addr_q <= wdata_i[IDX_W-1:0];
        pal_ph_q   <= PH_RED;
      end else if (wr_pal_data || rd_pal_data) begin
        if (wr_pal_data && pal_ph_q == PH_RED) pal_hold_q[2*CH_W-1:CH_W] <= wdata_i;
        if (wr_pal_data && pal_ph_q == PH_GRN) pal_hold_q[CH_W-1:0]      <= wdata_i;
        if (pal_ph_q == PH_BLU) pal_addr_q <= pal_addr_q + 1'b1;
        pal_ph_q <= ph_next(pal_ph_q);
      end

      if (wr_ovl_addr) begin
        ovl_addr_q <= wdata_i[OVL_W-1:0];
        ovl_ph_q   <= PH_RED;
      end else if (wr_ovl_data || rd_ovl_data) begin
        if (wr_ovl_data && ovl_ph_q == PH_RED) ovl_hold_q[2*CH_W-1:CH_W] <= wdata_i;
        if (wr_ovl_data && ovl_ph_q == PH_GRN) ovl_hold_q[CH_W-1:0]      <= wdata_i;
        if (ovl_ph_q == PH_BLU) ovl_addr_q <= ovl_addr_q + 1'b1;
        ovl_ph_q <= ph_next(ovl_ph_q);
      end

      if (!we_i && re_i) begin
        case (reg_i)
          REG_PAL_ADDR: rdata_q <= CH_W'(pal_addr_q);
          REG_PAL_DATA: rdata_q <= pick(pal_rword_i, pal_ph_q);
          REG_CMD:      rdata_q <= cmd_q;
          REG_OVL_ADDR: rdata_q <= CH_W'(ovl_addr_q);
          REG_OVL_DATA: rdata_q <= pick(ovl_q[ovl_addr_q], ovl_ph_q);
          default:      rdata_q <= '0;
        endcase
      end
    end
  end

  // command and overlay colors carry no reset value
  always_ff @(posedge clk_i) begin
    if (wr_cmd) cmd_q <= wdata_i;
  end

  for (genvar k = 0; k < N_OVL; k++) begin : g_ovl
    always_ff @(posedge clk_i) begin
      if (ovl_we && (ovl_addr_q == OVL_W'(k))) ovl_q[k] <= {ovl_hold_q, wdata_i};
    end
    assign ovl_regs_o[k*WORD_W +: WORD_W] = ovl_q[k];
  end

  assign pal_we_o    = wr_pal_data && (pal_ph_q == PH_BLU);
  assign pal_addr_o  = pal_addr_q;
  assign pal_wdata_o = {pal_hold_q, wdata_i};
  assign rdata_o     = rdata_q;
  assign cmd_o       = cmd_q;
endmodule

// File: rtl/pal_pix_pipe.sv
module pal_pix_pipe #(
  parameter int CH_W  = 8,
  parameter int OVL_W = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [OVL_W-1:0]             ovl_i,
  input  logic                         sync_ni,
  input  logic                         blank_ni,
  input  logic                         use_pal_i,
  input  logic [(1<<OVL_W)*3*CH_W-1:0] ovl_regs_i,
  input  logic [3*CH_W-1:0]            pal_word_i,
  output logic [3*CH_W-1:0]            rgb_o,
  output logic                         blank_no,
  output logic                         sync_no
);
  localparam int WORD_W = 3 * CH_W;

  logic              s1_pal_q, s1_sync_nq, s1_blank_nq;
  logic [WORD_W-1:0] s1_ovl_q;
  logic [WORD_W-1:0] s2_rgb_q;
  logic              s2_sync_nq, s2_blank_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_pal_q    <= 1'b0;
      s1_ovl_q    <= '0;
      s1_sync_nq  <= 1'b1;
      s1_blank_nq <= 1'b0;
      s2_rgb_q    <= '0;
      s2_sync_nq  <= 1'b1;
      s2_blank_nq <= 1'b0;
    end else begin
      s1_pal_q    <= (ovl_i == '0) && use_pal_i;
      s1_ovl_q    <= ovl_regs_i[ovl_i*WORD_W +: WORD_W];
      s1_sync_nq  <= sync_ni;
      s1_blank_nq <= blank_ni;
      s2_rgb_q    <= !s1_blank_nq ? '0 : (s1_pal_q ? pal_word_i : s1_ovl_q);
      s2_sync_nq  <= s1_sync_nq;
      s2_blank_nq <= s1_blank_nq;
    end
  end

  assign rgb_o    = s2_rgb_q;
  assign blank_no = s2_blank_nq;
  assign sync_no  = s2_sync_nq;
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top #(
  parameter int IDX_W       = 8,
  parameter int CH_W        = 8,
  parameter int OVL_W       = 2,
  parameter int CMD_PAL_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] pix_idx_i,
  input  logic [OVL_W-1:0] pix_ovl_i,
  input  logic             pix_sync_ni,
  input  logic             pix_blank_ni,
  input  logic             cpu_we_i,
  input  logic             cpu_re_i,
  input  logic [2:0]       cpu_reg_i,
  input  logic [CH_W-1:0]  cpu_wdata_i,
  output logic [CH_W-1:0]  cpu_rdata_o,
  output logic [CH_W-1:0]  red_o,
  output logic [CH_W-1:0]  grn_o,
  output logic [CH_W-1:0]  blu_o,
  output logic             blank_no,
  output logic             grn_sync_no
);
  localparam int WORD_W = 3 * CH_W;
  localparam int N_OVL  = 1 << OVL_W;

  logic                    pal_we;
  logic [IDX_W-1:0]        pal_addr;
  logic [WORD_W-1:0]       pal_wdata, pal_rword, pix_word, rgb;
  logic [CH_W-1:0]         cmd;
  logic [N_OVL*WORD_W-1:0] ovl_regs;

  pal_cpu_port #(.IDX_W(IDX_W), .CH_W(CH_W), .OVL_W(OVL_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cpu_we_i),
    .re_i       (cpu_re_i),
    .reg_i      (cpu_reg_i),
    .wdata_i    (cpu_wdata_i),
    .rdata_o    (cpu_rdata_o),
    .pal_we_o   (pal_we),
    .pal_addr_o (pal_addr),
    .pal_wdata_o(pal_wdata),
    .pal_rword_i(pal_rword),
    .cmd_o      (cmd),
    .ovl_regs_o (ovl_regs)
  );

  pal_ram #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_ram (
    .clk_i     (clk_i),
    .we_i      (pal_we),
    .waddr_i   (pal_addr),
    .wdata_i   (pal_wdata),
    .pix_addr_i(pix_idx_i),
    .pix_word_o(pix_word),
    .cpu_addr_i(pal_addr),
    .cpu_word_o(pal_rword)
  );

  pal_pix_pipe #(.CH_W(CH_W), .OVL_W(OVL_W)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovl_i     (pix_ovl_i),
    .sync_ni   (pix_sync_ni),
    .blank_ni  (pix_blank_ni),
    .use_pal_i (cmd[CMD_PAL_BIT]),
    .ovl_regs_i(ovl_regs),
    .pal_word_i(pix_word),
    .rgb_o     (rgb),
    .blank_no  (blank_no),
    .sync_no   (grn_sync_no)
  );

  assign red_o = rgb[3*CH_W-1:2*CH_W];
  assign grn_o = rgb[2*CH_W-1:CH_W];
  assign blu_o = rgb[CH_W-1:0];
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_sync_ni,
  input logic             pix_blank_ni,
  input logic [CH_W-1:0]  red_o,
  input logic [CH_W-1:0]  grn_o,
  input logic [CH_W-1:0]  blu_o,
  input logic             blank_no,
  input logic             grn_sync_no,
  input logic             pal_we_i,
  input logic [IDX_W-1:0] pal_addr_i
);
  logic [1:0] edges_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 1'b1;
  end
  assign warm = edges_q >= 2'd2;

  // R4
  a_r4_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_no |-> (red_o == '0 && grn_o == '0 && blu_o == '0));

  // R4, R6
  a_r4_blank_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> blank_no == $past(pix_blank_ni, 2));

  // R5, R6
  a_r5_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> grn_sync_no == $past(pix_sync_ni, 2));

  // R7
  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_i |=> pal_addr_i == IDX_W'($past(pal_addr_i) + 1'b1));
endmodule

bind pal_lut_top pal_lut_chk #(.IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_sync_ni (pix_sync_ni),
  .pix_blank_ni(pix_blank_ni),
  .red_o       (red_o),
  .grn_o       (grn_o),
  .blu_o       (blu_o),
  .blank_no    (blank_no),
  .grn_sync_no (grn_sync_no),
  .pal_we_i    (pal_we),
  .pal_addr_i  (pal_addr)
);

// File: tb/pal_lut_top_tb_top.sv
`timescale 1ns/1ps
module pal_lut_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pix_idx = '0;
  logic [1:0] pix_ovl = '0;
  logic       pix_sync_n = 1'b1, pix_blank_n = 1'b0;
  logic       cpu_we = 1'b0, cpu_re = 1'b0;
  logic [2:0] cpu_reg = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, red, grn, blu;
  logic       blank_n, sync_n;

  always #2.5 clk = ~clk;

  pal_lut_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_idx_i(pix_idx), .pix_ovl_i(pix_ovl),
    .pix_sync_ni(pix_sync_n), .pix_blank_ni(pix_blank_n),
    .cpu_we_i(cpu_we), .cpu_re_i(cpu_re), .cpu_reg_i(cpu_reg),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .red_o(red), .grn_o(grn), .blu_o(blu), .blank_no(blank_n), .grn_sync_no(sync_n)
  );

  int checks = 0, errors = 0;
  bit started = 0, done = 0, rnd_pix = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference model
  logic [23:0] m_pal [256];
  logic [23:0] m_ovl [4];
  logic [7:0]  m_cmd;
  int          m_paddr, m_pph, m_oaddr, m_oph;
  logic [15:0] m_phold, m_ohold;
  logic [7:0]  m_rdata;
  string       m_rtag;
  logic [23:0] e1_rgb, eo_rgb;
  logic        e1_blank, eo_blank, e1_sync, eo_sync;
  string       e1_tag, eo_tag;

  function automatic logic [7:0] pick(input logic [23:0] w, input int ph);
    return ph == 0 ? w[23:16] : (ph == 1 ? w[15:8] : w[7:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_paddr = 0; m_pph = 0; m_oaddr = 0; m_oph = 0;
      m_phold = '0; m_ohold = '0; m_rdata = '0; m_rtag = "R12";
      e1_rgb = '0; e1_blank = 0; e1_sync = 1; e1_tag = "R12";
      eo_rgb = '0; eo_blank = 0; eo_sync = 1; eo_tag = "R12";
    end else begin
      logic [23:0] w;
      string t;
      started = 1;
      eo_rgb = e1_rgb; eo_blank = e1_blank; eo_sync = e1_sync; eo_tag = e1_tag;
      if (pix_ovl != 0) begin w = m_ovl[pix_ovl]; t = "R1"; end
      else if (m_cmd[6]) begin
        w = m_pal[pix_idx];
        t = (cpu_we && cpu_reg == 1 && m_pph == 2 && m_paddr == int'(pix_idx)) ? "R11" : "R2";
      end else begin w = m_ovl[0]; t = "R3"; end
      if (!pix_blank_n) begin w = '0; t = "R4"; end
      e1_rgb = w; e1_blank = pix_blank_n; e1_sync = pix_sync_n; e1_tag = t;
      if (cpu_we) begin
        case (cpu_reg)
          0: begin m_paddr = cpu_wdata; m_pph = 0; end
          1: begin
            if (m_pph == 0) m_phold[15:8] = cpu_wdata;
            if (m_pph == 1) m_phold[7:0] = cpu_wdata;
            if (m_pph == 2) begin m_pal[m_paddr] = {m_phold, cpu_wdata}; m_paddr = (m_paddr + 1) % 256; end
            m_pph = (m_pph + 1) % 3;
          end
          2: m_cmd = cpu_wdata;
          3: begin m_oaddr = cpu_wdata % 4; m_oph = 0; end
          4: begin
            if (m_oph == 0) m_ohold[15:8] = cpu_wdata;
            if (m_oph == 1) m_ohold[7:0] = cpu_wdata;
            if (m_oph == 2) begin m_ovl[m_oaddr] = {m_ohold, cpu_wdata}; m_oaddr = (m_oaddr + 1) % 4; end
            m_oph = (m_oph + 1) % 3;
          end
          default: ;
        endcase
      end else if (cpu_re) begin
        case (cpu_reg)
          0: begin m_rdata = 8'(m_paddr); m_rtag = "R7"; end
          1: begin
            m_rdata = pick(m_pal[m_paddr], m_pph); m_rtag = "R8";
            if (m_pph == 2) m_paddr = (m_paddr + 1) % 256;
            m_pph = (m_pph + 1) % 3;
          end
          2: begin m_rdata = m_cmd; m_rtag = "R10"; end
          3: begin m_rdata = 8'(m_oaddr); m_rtag = "R9"; end
          4: begin
            m_rdata = pick(m_ovl[m_oaddr], m_oph); m_rtag = "R9";
            if (m_oph == 2) m_oaddr = (m_oaddr + 1) % 4;
            m_oph = (m_oph + 1) % 3;
          end
          default: begin m_rdata = '0; m_rtag = "R10"; end
        endcase
      end
    end
  end

  // compare every cycle, away from the rising edge; R6: color is two edges after its pixel
  always @(negedge clk) begin
    if (started || !rst_n) begin
      chk({8'h0, red, grn, blu}, {8'h0, eo_rgb}, {"R6,", eo_tag});
      chk(32'(blank_n), 32'(eo_blank), "R4 blank flag");
      chk(32'(sync_n), 32'(eo_sync), "R5 green sync");
      chk(32'(cpu_rdata), 32'(m_rdata), m_rtag);
    end
  end

  task automatic drive(input logic we, input logic re, input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    cpu_we = we; cpu_re = re; cpu_reg = r; cpu_wdata = d;
    if (rnd_pix) begin
      pix_idx = 8'($urandom); pix_ovl = 2'($urandom);
      pix_sync_n = 1'($urandom); pix_blank_n = ($urandom % 4) != 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(32'(blank_n), 32'h0, "R12 reset blank");
    chk(32'(sync_n), 32'h1, "R12 reset sync");
    rst_n = 1'b1;
    // load everything while blanked
    drive(1, 0, 2, 8'h40);
    drive(1, 0, 0, 8'h00);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) drive(1, 0, 1, 8'(i * 37 + c * 91 + 5));
    drive(1, 0, 3, 8'h00);
    for (int k = 0; k < 12; k++) drive(1, 0, 4, 8'(k * 53 + 3));
    // readbacks R8, R7, R10, R9
    drive(1, 0, 0, 8'd10);
    for (int k = 0; k < 6; k++) drive(0, 1, 1, 8'h00);
    drive(0, 1, 0, 8'h00);
    drive(0, 1, 2, 8'h00);
    drive(1, 0, 3, 8'd2);
    for (int k = 0; k < 7; k++) drive(0, 1, 4, 8'h00);
    drive(0, 1, 3, 8'h00);
    // R7 wrap from 255 to 0
    drive(1, 0, 0, 8'd255);
    drive(1, 0, 1, 8'h11); drive(1, 0, 1, 8'h22); drive(1, 0, 1, 8'h33);
    drive(0, 1, 0, 8'h00);
    // pixel lookups: R2, R3, R1 directed
    drive(0, 0, 0, 8'h00);
    pix_blank_n = 1; pix_ovl = 0; pix_idx = 8'd200;
    drive(1, 0, 2, 8'h00); pix_idx = 8'd201;
    drive(0, 0, 0, 8'h00); pix_ovl = 3;
    drive(1, 0, 2, 8'h40); pix_ovl = 0; pix_idx = 8'd255;
    drive(0, 0, 0, 8'h00);
    // R11 collision on entry 77
    drive(1, 0, 0, 8'd77);
    drive(1, 0, 1, 8'hA1); pix_idx = 8'd77;
    drive(1, 0, 1, 8'hB2);
    drive(1, 0, 1, 8'hC3);
    repeat (3) drive(0, 0, 0, 8'h00);
    // randomized mix
    rnd_pix = 1;
    for (int n = 0; n < 4000; n++) begin
      case ($urandom % 16)
        0: drive(1, 0, 2, 8'($urandom));
        1: drive(1, 0, 0, 8'($urandom));
        2, 3: drive(1, 0, 1, 8'($urandom));
        4: drive(0, 1, 1, 8'h00);
        5: drive(1, 0, 4, 8'($urandom));
        6: drive(0, 1, 4, 8'h00);
        7: drive(1, 0, 3, 8'($urandom));
        8: drive(0, 1, 2, 8'h00);
        9: drive(0, 1, 0, 8'h00);
        default: drive(0, 0, 0, 8'h00);
      endcase
    end
    rnd_pix = 0;
    repeat (4) drive(0, 0, 0, 8'h00);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule